// File: doc/BRIEF.md
# SPI Slave Port with Underflow Hold and Bit-Count Checking

This block is the serial engine of an SPI slave. It watches the bus clock, the data-in line and the slave select line, all of which arrive already synchronized to the system clock. It shifts words in and out with the most significant bit first. Data-in is sampled on rising bus-clock edges, and data-out moves on falling edges. Transmit words come from a show-ahead queue that the block pops. Received words are pushed to the receive side together with their bit count.

Slave select can be set active-high or active-low. Each activation restarts word framing. When slave select is released, the bit counter is checked against the configured word length. A frame that ends mid-word, or that never saw a clock, raises a bit-count error. The incomplete word is then either dropped or pushed with its real length, and that length is also kept in a status field. If the slave has nothing to send while a word is due, the data-out line is parked at a programmed level until the frame ends. In three-wire mode slave select is ignored, words are framed purely by counting clock edges, and a transmit underflow lasts only to the end of the current word.

Top module: `spi_slave_port`

## Requirements
- R1: After reset, all flags, the partial-count field, `rxPush` and `txPop` are 0. MISO shows `cfgUfLevel` while no word is loaded.
- R2: Slave select is active when `ss` equals `cfgSsActiveHigh`. Flag bit 0 sets when it becomes active and flag bit 1 sets when it becomes inactive. Every flag bit stays set until a 1 is written to the same bit of `flagClr`.
- R3: MOSI is sampled on every rising `sclk` edge inside an active frame, MSB first. After `cfgWordLen` samples (legal range 2..MAX_BITS), a word is pushed right-justified in `rxData`, with `rxBits` = `cfgWordLen`.
- R4: When slave select becomes active, and whenever the shift register is empty at a word boundary, a queued word is popped. Its bit `cfgWordLen`-1 is driven first, and MISO advances one bit on each falling `sclk` edge after a sampled bit. No pop happens in four-wire mode while slave select is inactive.
- R5: When slave select goes inactive, flag bit 2 (bit-count error) sets if the bit counter is nonzero, or if no rising edge arrived during the frame.
- R6: With `cfgKeepPartial`=1, a bit-count error pushes the incomplete word right-justified, with `rxBits` equal to the bits received, and `partialCount` records that number. With `cfgKeepPartial`=0, the word is dropped and `partialCount` reads 0. Clearing flag bit 2 also zeroes the recorded count.
- R7: Underflow (flag bit 3) happens when slave select becomes active with the queue empty, or when a rising edge starts a word with nothing loaded. MISO then holds `cfgUfLevel` and no word is popped until slave select goes inactive, even if data arrives.
- R8: A word queued after an underflow is sent as the first word of the next frame.
- R9: Flag bit 4 (under-run) sets when slave select goes inactive after an underflow in that frame.
- R10: With `cfgThreeWire`=1, `ss` has no effect. No select flags or bit-count errors are raised, words are framed every `cfgWordLen` rising edges, and an underflow hold ends at the next word boundary.
- R11: Each activation of slave select clears the bit counter and receive shift register, so a truncated frame does not disturb the next frame's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSsActiveHigh | input | 1 | Active level of slave select |
| cfgThreeWire | input | 1 | Ignore slave select, frame by edge count |
| cfgKeepPartial | input | 1 | Push incomplete words on bit-count error |
| cfgUfLevel | input | 1 | MISO level during underflow |
| cfgWordLen | input | CNT_W | Bits per word, 2..MAX_BITS |
| sclk | input | 1 | Bus clock, synchronized |
| mosi | input | 1 | Serial data in, synchronized |
| ss | input | 1 | Slave select, synchronized |
| miso | output | 1 | Serial data out |
| txValid | input | 1 | Transmit queue holds a word |
| txData | input | MAX_BITS | Head word of transmit queue |
| txPop | output | 1 | Consumes the head word this cycle |
| rxPush | output | 1 | Receive word valid for one cycle |
| rxData | output | MAX_BITS | Received word, right-justified |
| rxBits | output | CNT_W | Number of valid bits in rxData |
| flagClr | input | 5 | Write-1-to-clear per flag bit |
| flags | output | 5 | 0 select on, 1 select off, 2 bit-count error, 3 underflow, 4 under-run |
| partialCount | output | CNT_W | Bits in the last kept incomplete word |

## Verification
A corrupted bit counter would show up at the next word boundary. The word would be pushed early or late, with shifted `rxData`, or a bit-count error would appear when the frame closes. A stale transmit-loaded or hold state would show up at the next bit MISO drives, as a wrong bit value or an extra or missing `txPop`. Either fault becomes visible within one word time. The sweep covers several word lengths under both select polarities, which exposes off-by-one faults in the word-boundary compare and in the MSB index.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  localparam int FLAG_SS_ON  = 0;
  localparam int FLAG_SS_OFF = 1;
  localparam int FLAG_BITERR = 2;
  localparam int FLAG_UFLOW  = 3;
  localparam int FLAG_URUN   = 4;
  localparam int NUM_FLAGS   = 5;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrFrame;   // restart framing: counter and rx shifter to zero
    logic sample;     // rising sclk inside a frame
    logic wordDone;   // this sample completes a word
    logic commitPart; // push the incomplete word
    logic loadTx;     // capture head of transmit queue
    logic shiftTx;    // advance transmit shifter
  } dpStrobe_t;

endpackage

// File: rtl/spi_slave_dp.sv
module spi_slave_dp
  import spi_slave_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic                mosi,
  input  logic [MAX_BITS-1:0] txData,
  input  logic [CNT_W-1:0]    cfgWordLen,
  output logic [CNT_W-1:0]    bitCnt,
  output logic                frameHadBit,
  output logic                txMsb,
  output logic                rxPush,
  output logic [MAX_BITS-1:0] rxData,
  output logic [CNT_W-1:0]    rxBits
);

  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  logic [MAX_BITS-1:0] rxSh;
  logic [MAX_BITS-1:0] txSh;
  logic [MAX_BITS-1:0] rxNext;
  logic [IDX_W-1:0]    msbIdx;

  assign rxNext = {rxSh[MAX_BITS-2:0], mosi};
  assign msbIdx = IDX_W'(cfgWordLen - CNT_W'(1));
  assign txMsb  = txSh[msbIdx];

  // receive side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh        <= '0;
      bitCnt      <= '0;
      frameHadBit <= 1'b0;
      rxPush      <= 1'b0;
      rxData      <= '0;
      rxBits      <= '0;
    end else begin
      rxPush <= 1'b0;
      if (strb.commitPart) begin
        rxPush <= 1'b1;
        rxData <= rxSh;
        rxBits <= bitCnt;
      end
      if (strb.clrFrame) begin
        rxSh        <= '0;
        bitCnt      <= '0;
        frameHadBit <= 1'b0;
      end else if (strb.sample) begin
        frameHadBit <= 1'b1;
        if (strb.wordDone) begin
          rxPush <= 1'b1;
          rxData <= rxNext;
          rxBits <= cfgWordLen;
          rxSh   <= '0;
          bitCnt <= '0;
        end else begin
          rxSh   <= rxNext;
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
    end
  end

  // transmit side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
    end else if (strb.loadTx) begin
      txSh <= txData;
    end else if (strb.shiftTx) begin
      txSh <= {txSh[MAX_BITS-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_slave_ctrl.sv
module spi_slave_ctrl
  import spi_slave_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgSsActiveHigh,
  input  logic                 cfgThreeWire,
  input  logic                 cfgKeepPartial,
  input  logic                 cfgUfLevel,
  input  logic [CNT_W-1:0]     cfgWordLen,
  input  logic                 sclk,
  input  logic                 ss,
  input  logic                 txValid,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic [CNT_W-1:0]     bitCnt,
  input  logic                 frameHadBit,
  input  logic                 txMsb,
  output dpStrobe_t            strb,
  output logic                 txPop,
  output logic                 miso,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [CNT_W-1:0]     partialCount
);

  logic sclkQ, ssRawQ, txLoaded, ufHold;
  logic ssRaw, frameAct, ssStart, ssEnd, rise, fall;
  logic atWordStart, wordDone, bitErr, uflowEvt, loadTx, idleLoad;
  logic [NUM_FLAGS-1:0] flagSet;
  logic [CNT_W-1:0]     partialReg;

  always_comb begin
    ssRaw       = (ss == cfgSsActiveHigh);
    frameAct    = cfgThreeWire | ssRaw;
    ssStart     = ~cfgThreeWire & ssRaw & ~ssRawQ;
    ssEnd       = ~cfgThreeWire & ~ssRaw & ssRawQ;
    rise        = frameAct & sclk & ~sclkQ & ~ssStart;
    fall        = frameAct & ~sclk & sclkQ;
    atWordStart = (bitCnt == '0);
    wordDone    = rise & (bitCnt == cfgWordLen - CNT_W'(1));
    bitErr      = ssEnd & (~atWordStart | ~frameHadBit);

    // a word is fetched as soon as one is due and the queue offers it
    idleLoad = frameAct & ~ssStart & ~rise & ~txLoaded & ~ufHold &
               atWordStart & txValid;
    loadTx   = (ssStart & txValid) | idleLoad;
    // nothing to send when a frame opens or when a word's first edge arrives
    uflowEvt = (ssStart & ~txValid) |
               (rise & atWordStart & ~txLoaded & ~ufHold);

    strb.clrFrame   = ssStart | ssEnd;
    strb.sample     = rise;
    strb.wordDone   = wordDone;
    strb.commitPart = bitErr & cfgKeepPartial & ~atWordStart;
    strb.loadTx     = loadTx;
    strb.shiftTx    = fall & ~atWordStart & txLoaded & ~ufHold;

    flagSet                = '0;
    flagSet[FLAG_SS_ON]    = ssStart;
    flagSet[FLAG_SS_OFF]   = ssEnd;
    flagSet[FLAG_BITERR]   = bitErr;
    flagSet[FLAG_UFLOW]    = uflowEvt;
    flagSet[FLAG_URUN]     = ssEnd & ufHold;
  end

  assign txPop        = loadTx;
  assign miso         = (txLoaded & ~ufHold) ? txMsb : cfgUfLevel;
  assign partialCount = cfgKeepPartial ? partialReg : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      ssRawQ   <= 1'b0;
      txLoaded <= 1'b0;
      ufHold   <= 1'b0;
    end else begin
      sclkQ  <= sclk;
      ssRawQ <= ssRaw;

      if (ssEnd)         txLoaded <= 1'b0;
      else if (loadTx)   txLoaded <= 1'b1;
      else if (wordDone) txLoaded <= 1'b0;

      if (ssEnd)                           ufHold <= 1'b0;
      else if (uflowEvt)                   ufHold <= 1'b1;
      else if (cfgThreeWire & wordDone)    ufHold <= 1'b0;
    end
  end

  // sticky flags, a set in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      for (int i = 0; i < NUM_FLAGS; i++) begin
        flags[i] <= flagSet[i] | (flags[i] & ~flagClr[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partialReg <= '0;
    end else if (bitErr & cfgKeepPartial) begin
      partialReg <= bitCnt;
    end else if (flagClr[FLAG_BITERR]) begin
      partialReg <= '0;
    end
  end

endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
  import spi_slave_pkg::*;
#(
  parameter int MAX_BITS = 32,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgSsActiveHigh,
  input  logic                 cfgThreeWire,
  input  logic                 cfgKeepPartial,
  input  logic                 cfgUfLevel,
  input  logic [CNT_W-1:0]     cfgWordLen,
  input  logic                 sclk,
  input  logic                 mosi,
  input  logic                 ss,
  output logic                 miso,
  input  logic                 txValid,
  input  logic [MAX_BITS-1:0]  txData,
  output logic                 txPop,
  output logic                 rxPush,
  output logic [MAX_BITS-1:0]  rxData,
  output logic [CNT_W-1:0]     rxBits,
  input  logic [NUM_FLAGS-1:0] flagClr,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [CNT_W-1:0]     partialCount
);

  dpStrobe_t        strb;
  logic [CNT_W-1:0] bitCnt;
  logic             frameHadBit;
  logic             txMsb;

  spi_slave_ctrl #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cfgSsActiveHigh(cfgSsActiveHigh),
    .cfgThreeWire   (cfgThreeWire),
    .cfgKeepPartial (cfgKeepPartial),
    .cfgUfLevel     (cfgUfLevel),
    .cfgWordLen     (cfgWordLen),
    .sclk           (sclk),
    .ss             (ss),
    .txValid        (txValid),
    .flagClr        (flagClr),
    .bitCnt         (bitCnt),
    .frameHadBit    (frameHadBit),
    .txMsb          (txMsb),
    .strb           (strb),
    .txPop          (txPop),
    .miso           (miso),
    .flags          (flags),
    .partialCount   (partialCount)
  );

  spi_slave_dp #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .mosi       (mosi),
    .txData     (txData),
    .cfgWordLen (cfgWordLen),
    .bitCnt     (bitCnt),
    .frameHadBit(frameHadBit),
    .txMsb      (txMsb),
    .rxPush     (rxPush),
    .rxData     (rxData),
    .rxBits     (rxBits)
  );

endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk
  import spi_slave_pkg::*;
#(
  parameter int MAX_BITS = 32,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgSsActiveHigh,
  input logic                 cfgThreeWire,
  input logic                 cfgKeepPartial,
  input logic                 cfgUfLevel,
  input logic [CNT_W-1:0]     cfgWordLen,
  input logic                 ss,
  input logic                 miso,
  input logic                 txValid,
  input logic                 txPop,
  input logic                 rxPush,
  input logic [CNT_W-1:0]     rxBits,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [CNT_W-1:0]     bitCnt,
  input logic                 clrFrame
);

  p_pop_has_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> txValid);

  p_no_pop_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgThreeWire && ss != cfgSsActiveHigh) |-> !txPop);

  p_push_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> (rxBits != '0 && rxBits <= cfgWordLen));

  p_short_push_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxBits != cfgWordLen) |-> cfgKeepPartial);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < cfgWordLen);

  p_frame_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    clrFrame |=> bitCnt == '0);

  p_uflow_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_UFLOW]) |-> miso == cfgUfLevel);

  p_no_select_flags_3w_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgThreeWire && $past(cfgThreeWire)) |->
      (!$rose(flags[FLAG_SS_ON]) && !$rose(flags[FLAG_SS_OFF])));

endmodule

bind spi_slave_port spi_slave_port_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .cfgSsActiveHigh(cfgSsActiveHigh),
  .cfgThreeWire   (cfgThreeWire),
  .cfgKeepPartial (cfgKeepPartial),
  .cfgUfLevel     (cfgUfLevel),
  .cfgWordLen     (cfgWordLen),
  .ss             (ss),
  .miso           (miso),
  .txValid        (txValid),
  .txPop          (txPop),
  .rxPush         (rxPush),
  .rxBits         (rxBits),
  .flags          (flags),
  .bitCnt         (bitCnt),
  .clrFrame       (strb.clrFrame)
);

// File: tb/spi_slave_port_bench.sv
module spi_slave_port_bench;

  localparam int MAX_BITS = 32;
  localparam int CNT_W    = 6;

  logic clk = 1'b0;
  logic rstN;
  logic cfgHigh, cfgThree, cfgKeep, cfgUf;
  logic [CNT_W-1:0] cfgLen;
  logic sclk, mosi, ss, miso;
  logic txValid, txPop, rxPush;
  logic [MAX_BITS-1:0] txData, rxData;
  logic [CNT_W-1:0] rxBits, partialCount;
  logic [4:0] flagClr, flags;

  int checks = 0;
  int fails  = 0;

  // transmit queue model
  logic [MAX_BITS-1:0] q [0:7];
  logic [3:0] qHead = '0;
  logic [3:0] qTail = '0;
  assign txValid = (qHead != qTail);
  assign txData  = q[qHead[2:0]];
  always @(posedge clk) if (txPop) qHead <= qHead + 4'd1;

  // receive log
  logic [MAX_BITS-1:0] rxLogD [0:63];
  logic [CNT_W-1:0]    rxLogB [0:63];
  int rxN = 0;
  always @(negedge clk) if (rxPush) begin
    rxLogD[rxN % 64] = rxData;
    rxLogB[rxN % 64] = rxBits;
    rxN++;
  end

  always #2.5 clk = ~clk;

  spi_slave_port #(.MAX_BITS(MAX_BITS)) u_spi_slave_port (
    .clk(clk), .rstN(rstN), .cfgSsActiveHigh(cfgHigh), .cfgThreeWire(cfgThree),
    .cfgKeepPartial(cfgKeep), .cfgUfLevel(cfgUf), .cfgWordLen(cfgLen),
    .sclk(sclk), .mosi(mosi), .ss(ss), .miso(miso),
    .txValid(txValid), .txData(txData), .txPop(txPop),
    .rxPush(rxPush), .rxData(rxData), .rxBits(rxBits),
    .flagClr(flagClr), .flags(flags), .partialCount(partialCount)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qPush(input logic [MAX_BITS-1:0] d);
    q[qTail[2:0]] = d;
    qTail = qTail + 4'd1;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ssOn();  ss = cfgHigh;  waitN(4); endtask
  task automatic ssOff(); ss = ~cfgHigh; waitN(4); endtask

  task automatic clearFlags(input logic [4:0] m);
    flagClr = m; waitN(1); flagClr = '0; waitN(1);
  endtask

  // master side: n bits of w MSB first, collects miso read before each rise
  task automatic spiWord(input logic [31:0] w, input int n, output logic [31:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = w[i];
      waitN(4);
      got[i] = miso;
      sclk = 1'b1;
      waitN(4);
      sclk = 1'b0;
    end
    waitN(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] g0, g1, w0, w1, r0, r1, m;
    int base;
    rstN = 1'b0; sclk = 1'b0; mosi = 1'b0; ss = 1'b1; cfgHigh = 1'b0;
    cfgThree = 1'b0; cfgKeep = 1'b0; cfgUf = 1'b0; cfgLen = 6'd8; flagClr = '0;
    waitN(5);
    rstN = 1'b1;
    waitN(2);

    // R1 reset state
    check("R1 flags", flags, 0);
    check("R1 partialCount", partialCount, 0);
    check("R1 rxPush", rxPush, 0);
    check("R1 txPop", txPop, 0);
    check("R1 miso idle", miso, 0);

    // R2 R3 R4 R11 sweep over polarity and word length
    for (int pol = 0; pol < 2; pol++) begin
      for (int k = 0; k < 4; k++) begin
        int wl;
        wl = (k == 0) ? 2 : (k == 1) ? 5 : (k == 2) ? 8 : 13;
        cfgHigh = pol[0]; ss = ~pol[0]; cfgLen = wl[CNT_W-1:0];
        waitN(2);
        m  = (32'd1 << wl) - 1;
        w0 = (32'hA5C3_96E1 ^ (wl * 32'h1111)) & m;
        w1 = ~w0 & m;
        r0 = (32'h5A3C_0F69 + wl * 32'h0357) & m;
        r1 = (r0 ^ 32'h0000_1F2B) & m;
        qPush(w0); qPush(w1);
        base = rxN;
        ssOn();
        check("R2 select-on flag", flags[0], 1);
        spiWord(r0, wl, g0);
        spiWord(r1, wl, g1);
        ssOff();
        check("R4 first tx word", g0, w0);
        check("R4 second tx word", g1, w1);
        check("R3 push count", rxN - base, 2);
        check("R3 rx word 0", rxLogD[base % 64], r0);
        check("R3 rx word 1", rxLogD[(base + 1) % 64], r1);
        check("R3 rx bits", rxLogB[base % 64], wl);
        check("R2 select-off flag", flags[1], 1);
        check("R5 no error on whole words", flags[2], 0);
        check("R7 no underflow with data", flags[3], 0);
        clearFlags(5'h1F);
        check("R2 flags cleared", flags, 0);
      end
    end

    // R5 R6 keep partial word
    cfgHigh = 1'b0; ss = 1'b1; cfgLen = 6'd8; cfgKeep = 1'b1;
    waitN(2);
    qPush(32'h3C);
    base = rxN;
    ssOn();
    spiWord(32'h5, 3, g0);
    ssOff();
    check("R5 bit error flag", flags[2], 1);
    check("R6 partial pushed", rxN - base, 1);
    check("R6 partial data", rxLogD[base % 64], 32'h5);
    check("R6 partial bits", rxLogB[base % 64], 3);
    check("R6 partial count", partialCount, 3);
    check("R4 partial tx bits", g0, 32'h1);
    clearFlags(5'b00100);
    check("R6 count cleared with flag", partialCount, 0);
    check("R6 error flag cleared", flags[2], 0);
    clearFlags(5'h1F);

    // R11 full word after truncated frame
    qPush(32'hE7);
    base = rxN;
    ssOn();
    spiWord(32'h96, 8, g0);
    ssOff();
    check("R11 word after partial", rxLogD[base % 64], 32'h96);
    check("R11 tx after partial", g0, 32'hE7);
    check("R11 no error", flags[2], 0);
    clearFlags(5'h1F);

    // R6 drop partial word
    cfgKeep = 1'b0;
    qPush(32'h11);
    base = rxN;
    ssOn();
    spiWord(32'h1B, 5, g0);
    ssOff();
    check("R6 dropped word", rxN - base, 0);
    check("R6 count reads zero", partialCount, 0);
    check("R5 error on dropped", flags[2], 1);
    clearFlags(5'h1F);

    // R5 R7 R9 frame with no clocks and empty queue
    ssOn();
    check("R7 underflow at select", flags[3], 1);
    check("R9 no under-run while active", flags[4], 0);
    ssOff();
    check("R5 error without clocks", flags[2], 1);
    check("R9 under-run at release", flags[4], 1);
    clearFlags(5'h1F);

    // R7 R8 underflow after a word, data arriving mid-hold
    cfgUf = 1'b1;
    qPush(32'hC5);
    base = rxN;
    ssOn();
    spiWord(32'h3A, 8, g0);
    spiWord(32'h2, 2, g1);
    qPush(32'h6B);
    waitN(4);
    spiWord(32'h21, 6, w0);
    check("R7 no pop during hold", qTail - qHead, 1);
    check("R9 under-run waits for release", flags[4], 0);
    ssOff();
    check("R4 word before underflow", g0, 32'hC5);
    check("R7 held level", {g1[1:0], w0[5:0]}, 8'hFF);
    check("R7 underflow flag", flags[3], 1);
    check("R9 under-run flag", flags[4], 1);
    check("R3 rx during underflow", rxLogD[(base + 1) % 64], 32'hA1);
    clearFlags(5'h1F);
    ssOn();
    spiWord(32'h00, 8, g0);
    ssOff();
    check("R8 late word sent next frame", g0, 32'h6B);
    check("R8 no underflow next frame", flags[3], 0);
    clearFlags(5'h1F);

    // R7 underflow at select, data pushed right after
    ssOn();
    qPush(32'h00);
    spiWord(32'h00, 8, g0);
    ssOff();
    check("R7 hold despite new data", g0, 32'hFF);
    clearFlags(5'h1F);
    ssOn();
    spiWord(32'h00, 8, g0);
    ssOff();
    check("R8 zero word next frame", g0, 32'h00);
    clearFlags(5'h1F);

    // R10 three-wire mode
    cfgThree = 1'b1; cfgUf = 1'b1;
    waitN(2);
    ss = 1'b0; waitN(3); ss = 1'b1; waitN(3);
    check("R10 select ignored", flags[1:0], 0);
    qPush(32'h81); qPush(32'h7E);
    waitN(4);
    base = rxN;
    spiWord(32'hD4 >> 4, 4, g0);
    ss = 1'b0; waitN(3); ss = 1'b1; waitN(3);
    spiWord(32'h4, 4, g1);
    spiWord(32'h39, 8, w0);
    check("R10 tx word 0", {g0[3:0], g1[3:0]}, 32'h81);
    check("R10 tx word 1", w0, 32'h7E);
    check("R10 rx word 0", rxLogD[base % 64], 32'hD4);
    check("R10 rx word 1", rxLogD[(base + 1) % 64], 32'h39);
    spiWord(32'hF0, 8, g0);
    check("R10 underflow level", g0, 32'hFF);
    check("R10 underflow flag", flags[3], 1);
    check("R10 rx during underflow", rxLogD[(base + 2) % 64], 32'hF0);
    qPush(32'h55);
    waitN(4);
    spiWord(32'h0F, 8, g0);
    check("R10 hold ends at word", g0, 32'h55);
    check("R10 no select or count flags", {flags[2], flags[1:0]}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule